// File: doc/BRIEF.md
# Paged Register Address Decoder

This block sits between a host command layer and an internal register bank. Each host command names a register with only a 5-bit short address. The internal register space is 12 bits wide. The block widens the short address by placing a 7-bit page value above it. This gives 128 pages of 32 locations each.

The page value lives in a write-only page register at short address 31. That slot is decoded ahead of everything else, so software can always reach it, whatever page is selected. A page write changes the internal address from the next command on.

Only part of the internal space holds real registers. Two parameters set the populated region: a count of pages from page 0 upward, and a count of low slots within each populated page. A write that falls outside this region is dropped. A read outside it returns zero and does not strobe the bank.

Top module: `paged_reg_decoder`

## Requirements
- R1: After reset the page value is 0, so a command to short address `a` drives internal address `{7'd0, a}`.
- R2: For every populated access the internal address equals `{page[6:0], cmdAddr[4:0]}`.
- R3: A write to short address 31 loads the page from `cmdWdata[6:0]` and raises no bank write enable.
- R4: A page write is accepted from any selected page, including unpopulated ones, and is used by the next command.
- R5: A read of short address 31 returns zero on `cmdRdata` and raises no bank read enable.
- R6: A write is unpopulated when the page is at least POP_PAGES or the short address is at least POP_REGS, and is not 31. Such a write raises no bank write enable, and bank contents stay unchanged.
- R7: A read of an unpopulated location returns zero and raises no bank read enable.
- R8: A read of a populated location raises `bankRdEn` in the same cycle and passes `bankRdata` straight to `cmdRdata`.
- R9: When read and write strobes arrive together, only the write is carried out. The bank read enable stays low and `cmdRdata` is zero.
- R10: During a bank write, `bankWdata` equals `cmdWdata`, and the bank captures it on that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdRd | input | 1 | Host read strobe, one cycle per command |
| cmdWr | input | 1 | Host write strobe, one cycle per command |
| cmdAddr | input | 5 | Short register address |
| cmdWdata | input | DATA_W | Host write data |
| cmdRdata | output | DATA_W | Read data back to host, zero when no bank read |
| bankAddr | output | 12 | Internal address `{page, cmdAddr}` |
| bankRdEn | output | 1 | Bank read enable |
| bankWrEn | output | 1 | Bank write enable |
| bankWdata | output | DATA_W | Data written to the bank |
| bankRdata | input | DATA_W | Combinational read data from the bank |

## Verification
The assertions assume that the host strobes are never unknown once reset is released. They also assume that the bank returns read data within the cycle in which `bankRdEn` is high. The stimulus drives every command on the falling edge and holds it for exactly one cycle. It returns both strobes to zero between commands and models the bank as a combinational read with a clocked write. Collisions are produced only on purpose, in the scenario that covers simultaneous strobes.

// File: rtl/pagedec_pkg.sv
package pagedec_pkg;
  typedef struct packed {
    logic pageLoad;
    logic bankWr;
    logic bankRd;
  } decStrb_t;
endpackage

// File: rtl/pagedec_ctrl.sv
module pagedec_ctrl
  import pagedec_pkg::*;
#(
  parameter int SHORT_W   = 5,
  parameter int PAGE_W    = 7,
  parameter int POP_PAGES = 4,
  parameter int POP_REGS  = 24
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cmdRd,
  input  logic               cmdWr,
  input  logic [SHORT_W-1:0] cmdAddr,
  input  logic [PAGE_W-1:0]  pageQ,
  output decStrb_t           strb
);
  localparam logic [SHORT_W-1:0] PAGE_SLOT   = {SHORT_W{1'b1}};
  localparam logic [PAGE_W:0]    PAGE_LIMIT  = (PAGE_W+1)'(POP_PAGES);
  localparam logic [SHORT_W:0]   SLOT_LIMIT  = (SHORT_W+1)'(POP_REGS);

  logic isSlot;
  logic inRegion;

  always_comb begin
    isSlot   = (cmdAddr == PAGE_SLOT);
    inRegion = ({1'b0, pageQ} < PAGE_LIMIT) && ({1'b0, cmdAddr} < SLOT_LIMIT) && !isSlot;
    strb.pageLoad = cmdWr && isSlot;
    strb.bankWr   = cmdWr && inRegion;
    strb.bankRd   = cmdRd && !cmdWr && inRegion;
  end

  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.bankRd && strb.bankWr)); // R9
  AST_SLOT_NO_BANK: assert property (@(posedge clk) disable iff (!rstN)
    (cmdAddr == PAGE_SLOT) |-> !(strb.bankWr || strb.bankRd)); // R5
  AST_BANKWR_NEEDS_CMD: assert property (@(posedge clk) disable iff (!rstN)
    strb.bankWr |-> cmdWr); // R6
endmodule

// File: rtl/pagedec_dp.sv
module pagedec_dp
  import pagedec_pkg::*;
#(
  parameter int SHORT_W = 5,
  parameter int PAGE_W  = 7,
  parameter int DATA_W  = 24
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  decStrb_t                  strb,
  input  logic [SHORT_W-1:0]        cmdAddr,
  input  logic [DATA_W-1:0]         cmdWdata,
  input  logic [DATA_W-1:0]         bankRdata,
  output logic [PAGE_W-1:0]         pageQ,
  output logic [PAGE_W+SHORT_W-1:0] bankAddr,
  output logic                      bankRdEn,
  output logic                      bankWrEn,
  output logic [DATA_W-1:0]         bankWdata,
  output logic [DATA_W-1:0]         cmdRdata
);
  logic [PAGE_W-1:0] pageNext;

  generate
    if (DATA_W >= PAGE_W) begin : g_wide
      assign pageNext = cmdWdata[PAGE_W-1:0];
    end else begin : g_narrow
      assign pageNext = {{(PAGE_W-DATA_W){1'b0}}, cmdWdata};
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pageQ <= '0;
    else if (strb.pageLoad) pageQ <= pageNext;
  end

  always_comb begin
    bankAddr  = {pageQ, cmdAddr};
    bankRdEn  = strb.bankRd;
    bankWrEn  = strb.bankWr;
    bankWdata = cmdWdata;
    cmdRdata  = strb.bankRd ? bankRdata : '0;
  end

  AST_PAGE_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strb.pageLoad |=> (pageQ == $past(pageNext))); // R3
  AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.pageLoad |=> $stable(pageQ)); // R4
  AST_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !bankRdEn |-> (cmdRdata == '0)); // R7
endmodule

// File: rtl/paged_reg_decoder.sv
module paged_reg_decoder
  import pagedec_pkg::*;
#(
  parameter int DATA_W    = 24,
  parameter int POP_PAGES = 4,
  parameter int POP_REGS  = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdRd,
  input  logic              cmdWr,
  input  logic [4:0]        cmdAddr,
  input  logic [DATA_W-1:0] cmdWdata,
  output logic [DATA_W-1:0] cmdRdata,
  output logic [11:0]       bankAddr,
  output logic              bankRdEn,
  output logic              bankWrEn,
  output logic [DATA_W-1:0] bankWdata,
  input  logic [DATA_W-1:0] bankRdata
);
  localparam int SHORT_W = 5;
  localparam int PAGE_W  = 7;

  decStrb_t          strb;
  logic [PAGE_W-1:0] pageQ;

  pagedec_ctrl #(.SHORT_W(SHORT_W), .PAGE_W(PAGE_W),
                 .POP_PAGES(POP_PAGES), .POP_REGS(POP_REGS)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdRd(cmdRd), .cmdWr(cmdWr),
    .cmdAddr(cmdAddr), .pageQ(pageQ), .strb(strb)
  );

  pagedec_dp #(.SHORT_W(SHORT_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cmdAddr(cmdAddr),
    .cmdWdata(cmdWdata), .bankRdata(bankRdata), .pageQ(pageQ),
    .bankAddr(bankAddr), .bankRdEn(bankRdEn), .bankWrEn(bankWrEn),
    .bankWdata(bankWdata), .cmdRdata(cmdRdata)
  );

  AST_ADDR_LOW_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (bankWrEn || bankRdEn) |-> (bankAddr[4:0] == cmdAddr)); // R2
  AST_WDATA_PASS: assert property (@(posedge clk) disable iff (!rstN)
    bankWrEn |-> (bankWdata == cmdWdata)); // R10
endmodule

// File: tb/paged_reg_decoder_tb.sv
module paged_reg_decoder_tb;
  localparam int DW = 24;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cmdRd = 1'b0, cmdWr = 1'b0;
  logic [4:0]    cmdAddr = '0;
  logic [DW-1:0] cmdWdata = '0;
  logic [DW-1:0] cmdRdata, bankWdata, bankRdata;
  logic [11:0]   bankAddr;
  logic          bankRdEn, bankWrEn;
  logic [DW-1:0] mem [256];
  int nChecks = 0, nFails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  paged_reg_decoder #(.DATA_W(DW), .POP_PAGES(4), .POP_REGS(24)) u_dut (
    .clk(clk), .rstN(rstN), .cmdRd(cmdRd), .cmdWr(cmdWr), .cmdAddr(cmdAddr),
    .cmdWdata(cmdWdata), .cmdRdata(cmdRdata), .bankAddr(bankAddr),
    .bankRdEn(bankRdEn), .bankWrEn(bankWrEn), .bankWdata(bankWdata),
    .bankRdata(bankRdata)
  );

  assign bankRdata = mem[bankAddr[7:0]];
  always @(posedge clk) if (bankWrEn) mem[bankAddr[7:0]] <= bankWdata;

  task automatic chk(bit ok, string req, longint act, longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hostWrite(logic [4:0] a, logic [DW-1:0] d, bit expWr,
                           logic [11:0] expAddr, string req);
    @(negedge clk);
    cmdWr = 1'b1; cmdAddr = a; cmdWdata = d;
    #1;
    chk(bankWrEn == expWr, req, bankWrEn, expWr);
    if (expWr) begin
      chk(bankAddr == expAddr, req, bankAddr, expAddr);
      chk(bankWdata == d, "R10", bankWdata, d);
    end
    @(negedge clk);
    cmdWr = 1'b0;
  endtask

  task automatic hostRead(logic [4:0] a, bit expRd, logic [11:0] expAddr,
                          logic [DW-1:0] expData, string req);
    @(negedge clk);
    cmdRd = 1'b1; cmdAddr = a;
    #1;
    chk(bankRdEn == expRd, req, bankRdEn, expRd);
    if (expRd) chk(bankAddr == expAddr, req, bankAddr, expAddr);
    chk(cmdRdata == expData, req, cmdRdata, expData);
    @(negedge clk);
    cmdRd = 1'b0;
  endtask

  task automatic testReset();
    chk(bankWrEn == 1'b0 && bankRdEn == 1'b0, "R1 idle", {bankWrEn, bankRdEn}, 0);
    hostWrite(5'd3, 24'h00A003, 1'b1, 12'h003, "R1");
    hostRead(5'd3, 1'b1, 12'h003, 24'h00A003, "R8");
  endtask

  task automatic testPageSwitch();
    hostWrite(5'd31, 24'hFFFF02, 1'b0, 12'h000, "R3");
    chk(mem[8'h1F] == 24'h0, "R3 slot bank", mem[8'h1F], 0);
    hostWrite(5'd7, 24'h123456, 1'b1, {7'd2, 5'd7}, "R2");
    hostRead(5'd7, 1'b1, {7'd2, 5'd7}, 24'h123456, "R8");
    hostRead(5'd31, 1'b0, 12'h000, 24'h0, "R5");
    hostWrite(5'd31, 24'h000001, 1'b0, 12'h000, "R4");
    hostWrite(5'd23, 24'h0BEEF1, 1'b1, {7'd1, 5'd23}, "R4");
    chk(mem[{3'd1, 5'd23}] == 24'h0BEEF1, "R10 captured", mem[{3'd1, 5'd23}], 24'h0BEEF1);
  endtask

  task automatic testReserved();
    hostWrite(5'd24, 24'h777777, 1'b0, 12'h000, "R6");
    chk(mem[{3'd1, 5'd24}] == 24'h0, "R6 mem", mem[{3'd1, 5'd24}], 0);
    hostRead(5'd24, 1'b0, 12'h000, 24'h0, "R7");
    hostWrite(5'd31, 24'h000005, 1'b0, 12'h000, "R3");
    hostWrite(5'd2, 24'h555555, 1'b0, 12'h000, "R6");
    chk(mem[{3'd5, 5'd2}] == 24'h0, "R6 mem", mem[{3'd5, 5'd2}], 0);
    hostRead(5'd2, 1'b0, 12'h000, 24'h0, "R7");
    hostWrite(5'd31, 24'h000000, 1'b0, 12'h000, "R4");
    hostRead(5'd3, 1'b1, 12'h003, 24'h00A003, "R4");
  endtask

  task automatic testCollision();
    @(negedge clk);
    cmdWr = 1'b1; cmdRd = 1'b1; cmdAddr = 5'd9; cmdWdata = 24'hC0FFEE;
    #1;
    chk(bankWrEn == 1'b1, "R9 wr", bankWrEn, 1);
    chk(bankRdEn == 1'b0, "R9 rd", bankRdEn, 0);
    chk(cmdRdata == '0, "R9 data", cmdRdata, 0);
    @(negedge clk);
    cmdWr = 1'b0; cmdRd = 1'b0;
    hostRead(5'd9, 1'b1, 12'h009, 24'hC0FFEE, "R9");
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testPageSwitch();
    testReserved();
    testCollision();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule